// File: doc/BRIEF.md
# Linear Encoder Position, Velocity and Reference Profile Unit

This block sits between the A/B quadrature outputs of a linear position encoder and a motion controller. Each encoder line is synchronised and debounced on its own. The clean pair is then decoded into a one-cycle count pulse with a direction bit, and both feed a saturating up/down position counter. One count is 0.1 mm, so 1000 counts span 0.1 m.

A sample-rate divider produces a one-cycle tick. The default divide ratio gives about 732 Hz from a 24 MHz clock. On every tick the block latches a velocity value, which is the change in position since the previous tick.

On the same tick the block also advances a periodic reference trajectory for the position loop to follow. A select input chooses between a sinusoid-shaped profile and a trapezoid made of linear ramps and flat holds. All three results are 12-bit two's-complement values in the range -2048 to +2047.

Top module: `linenc_track`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset is released, `pos`, `vel` and `ref_pos` read 0, and `step_pulse`, `step_up` and `quad_err` read 0.
- R2: Each encoder line passes through a two-flop synchroniser and then a debounce filter. The filter takes a new level only after that level has been present for FILT_N consecutive clocks. A pulse that lasts FILT_N-1 clocks leaves `pos` unchanged.
- R3: The filtered pair is written {A,B}. Every single-line change is counted, which gives four counts per encoder cycle. The sequence 00→01→11→10→00 counts up and the reverse sequence counts down. Each legal change raises `step_pulse` for one cycle, and `step_up` is 1 during that cycle for an up count. `pos` changes by exactly one in the following cycle, and at no other time.
- R4: When both filtered lines change in the same cycle, `quad_err` is high for one cycle and `pos` does not change.
- R5: In the cycle after each `sample_tick`, `vel` equals the `pos` seen during that tick minus the `pos` seen during the previous tick (0 before the first tick). The result is saturated to 12 bits, and `vel` holds its value between ticks.
- R6: `sample_tick` is high for one cycle once every SAMPLE_DIV clocks. The default of 32787 gives about 732 Hz at 24 MHz.
- R7: `pos` saturates at +2047 and -2048. Counts beyond either limit are dropped, and a count in the opposite direction moves away from the limit at once.
- R8: With `traj_sel`=0, and with H = 2^HALF_LOG2 and k the tick count since the last restart taken modulo 2H, `ref_pos` after tick k equals (AMP·4·k·(H-k))>>(2·HALF_LOG2) for k<H. For k≥H it is the negative of the same expression evaluated at k-H.
- R9: A change of `traj_sel` restarts the profile. In the next cycle `ref_pos` is 0 and the tick count is 0, and this restart takes precedence over a tick in the same cycle.
- R10: With `traj_sel`=1, and with R = 2^RAMP_LOG2 and a period of 4R+2·HOLD ticks, the profile rises linearly from 0 to AMP over R ticks, holds AMP for HOLD ticks, falls linearly over 2R ticks, holds -AMP for HOLD ticks, and rises over R ticks back toward 0. Each ramp step is (AMP·j)>>RAMP_LOG2, where j is the tick count within that ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Raw encoder line A |
| enc_b | input | 1 | Raw encoder line B |
| traj_sel | input | 1 | Profile select: 0 sinusoid, 1 trapezoid |
| pos | output | 12 | Signed position count |
| vel | output | 12 | Signed per-sample position change |
| ref_pos | output | 12 | Signed reference trajectory value |
| step_pulse | output | 1 | One-cycle pulse for each legal quadrature edge |
| step_up | output | 1 | Direction of the current count, 1 for up |
| quad_err | output | 1 | One-cycle flag when both lines change at once |
| sample_tick | output | 1 | One-cycle sample-rate strobe |

## Verification
The bound properties check the following on every cycle:
- `pos` moves by one only after a count pulse, in the signalled direction.
- `pos` stays unchanged after an illegal transition.
- `vel` and `ref_pos` change only on a sample tick, or on a profile restart for `ref_pos`.
- The sample tick never lasts longer than one cycle.

Only the bench scenarios can show the rest:
- glitch rejection by the debounce filter;
- the four-counts-per-cycle decode across several move sequences;
- saturation at the upper limit;
- the tick period;
- the exact sample-by-sample values of both reference profiles, including wrap-around and restart.

// File: rtl/linenc_track.sv
module linenc_track #(
  parameter int FILT_N     = 8,
  parameter int SAMPLE_DIV = 32787,
  parameter int AMP        = 1000,
  parameter int HALF_LOG2  = 8,
  parameter int RAMP_LOG2  = 7,
  parameter int HOLD       = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enc_a,
  input  logic               enc_b,
  input  logic               traj_sel,
  output logic signed [11:0] pos,
  output logic signed [11:0] vel,
  output logic signed [11:0] ref_pos,
  output logic               step_pulse,
  output logic               step_up,
  output logic               quad_err,
  output logic               sample_tick
);
  localparam int FC_W  = $clog2(FILT_N + 1);
  localparam int DIV_W = $clog2(SAMPLE_DIV + 1);
  localparam int H     = 1 << HALF_LOG2;
  localparam int SP    = 2 * H;
  localparam int R     = 1 << RAMP_LOG2;
  localparam int TP    = 4 * R + 2 * HOLD;
  localparam int PMAX  = (SP > TP) ? SP : TP;
  localparam int PH_W  = $clog2(PMAX + 1);

  logic [1:0] raw, filt, ab_q, chg;
  assign raw = {enc_a, enc_b};

  for (genvar i = 0; i < 2; i++) begin : g_flt
    logic [1:0]      sync;
    logic [FC_W-1:0] cnt;
    logic            lvl;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sync <= '0;
        cnt  <= '0;
        lvl  <= 1'b0;
      end else begin
        sync <= {sync[0], raw[i]};
        if (sync[1] == lvl) cnt <= '0;
        else if (cnt == FC_W'(FILT_N - 1)) begin
          lvl <= sync[1];
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
      end
    end
    assign filt[i] = lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ab_q <= 2'b00;
    else        ab_q <= filt;
  end

  assign chg        = filt ^ ab_q;
  assign step_pulse = ^chg;
  assign quad_err   = &chg;
  assign step_up    = step_pulse & (ab_q[1] ^ filt[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) pos <= '0;
    else if (step_pulse) begin
      if (step_up && pos != 12'sh7FF)       pos <= pos + 12'sd1;
      else if (!step_up && pos != 12'sh800) pos <= pos - 12'sd1;
    end
  end

  logic [DIV_W-1:0] div_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt     <= '0;
      sample_tick <= 1'b0;
    end else begin
      sample_tick <= (div_cnt == DIV_W'(SAMPLE_DIV - 1));
      div_cnt     <= (div_cnt == DIV_W'(SAMPLE_DIV - 1)) ? '0 : div_cnt + 1'b1;
    end
  end

  logic signed [11:0] pos_last;
  logic signed [12:0] dv;
  logic signed [11:0] dv_sat;
  assign dv = $signed({pos[11], pos}) - $signed({pos_last[11], pos_last});
  always_comb begin
    if (dv > 13'sd2047)       dv_sat = 12'sh7FF;
    else if (dv < -13'sd2048) dv_sat = 12'sh800;
    else                      dv_sat = dv[11:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_last <= '0;
      vel      <= '0;
    end else if (sample_tick) begin
      pos_last <= pos;
      vel      <= dv_sat;
    end
  end

  function automatic logic signed [11:0] shape(input logic sel, input logic [PH_W-1:0] ph);
    int k, v;
    k = int'(ph);
    if (!sel) begin
      if (k < H) v = (AMP * 4 * k * (H - k)) >>> (2 * HALF_LOG2);
      else       v = -((AMP * 4 * (k - H) * (SP - k)) >>> (2 * HALF_LOG2));
    end else begin
      if (k < R)                 v = (AMP * k) >>> RAMP_LOG2;
      else if (k < R + HOLD)     v = AMP;
      else if (k < 3 * R + HOLD) v = AMP - ((AMP * (k - R - HOLD)) >>> RAMP_LOG2);
      else if (k < 3 * R + 2 * HOLD) v = -AMP;
      else v = -AMP + ((AMP * (k - 3 * R - 2 * HOLD)) >>> RAMP_LOG2);
    end
    return 12'(v);
  endfunction

  logic [PH_W-1:0] ph, ph_nx;
  logic            sel_q;
  assign ph_nx = traj_sel ? ((ph == PH_W'(TP - 1)) ? '0 : ph + 1'b1)
                          : ((ph == PH_W'(SP - 1)) ? '0 : ph + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= '0;
      sel_q   <= 1'b0;
      ref_pos <= '0;
    end else if (traj_sel != sel_q) begin
      sel_q   <= traj_sel;
      ph      <= '0;
      ref_pos <= '0;
    end else if (sample_tick) begin
      ph      <= ph_nx;
      ref_pos <= shape(traj_sel, ph_nx);
    end
  end
endmodule

module linenc_track_chk (
  input logic               clk,
  input logic               rst_n,
  input logic               traj_sel,
  input logic signed [11:0] pos,
  input logic signed [11:0] vel,
  input logic signed [11:0] ref_pos,
  input logic               step_pulse,
  input logic               step_up,
  input logic               quad_err,
  input logic               sample_tick
);
  assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && step_up && pos != 12'sh7FF) |=> pos == $past(pos) + 12'sd1);
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && !step_up && pos != 12'sh800) |=> pos == $past(pos) - 12'sd1);
  assert_hold_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_pulse |=> $stable(pos));
  assert_err_no_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    quad_err |=> $stable(pos));
  assert_vel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(vel));
  assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);
  assert_ref_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_tick && $stable(traj_sel)) |=> $stable(ref_pos));
endmodule

bind linenc_track linenc_track_chk u_chk (
  .clk(clk), .rst_n(rst_n), .traj_sel(traj_sel), .pos(pos), .vel(vel),
  .ref_pos(ref_pos), .step_pulse(step_pulse), .step_up(step_up),
  .quad_err(quad_err), .sample_tick(sample_tick)
);

// File: tb/sim_linenc_track.sv
module sim_linenc_track;
  localparam int CLK_P = 10;
  localparam int FN = 3, DIV = 40, AMPL = 1000, HL = 3, RL = 2, HLD = 3;
  localparam int HH = 1 << HL, RR = 1 << RL;
  localparam int VEC [5][3] = '{'{4, 1, 4}, '{10, 1, 14}, '{6, 0, 8}, '{1, 0, 7}, '{20, 0, -13}};

  logic clk = 0, rst_n = 0, enc_a = 0, enc_b = 0, traj_sel = 0;
  logic signed [11:0] pos, vel, ref_pos;
  logic step_pulse, step_up, quad_err, sample_tick;
  int checks = 0, errors = 0, err_seen = 0, vel_last = 0;
  bit vel_pending = 0;
  logic [1:0] g = 0;

  always #(CLK_P / 2) clk = ~clk;

  linenc_track #(.FILT_N(FN), .SAMPLE_DIV(DIV), .AMP(AMPL), .HALF_LOG2(HL),
                 .RAMP_LOG2(RL), .HOLD(HLD)) u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .traj_sel(traj_sel),
    .pos(pos), .vel(vel), .ref_pos(ref_pos), .step_pulse(step_pulse),
    .step_up(step_up), .quad_err(quad_err), .sample_tick(sample_tick));

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int sat12(input int v);
    return v > 2047 ? 2047 : (v < -2048 ? -2048 : v);
  endfunction

  function automatic int sine_ref(input int k);
    if (k < HH) return (AMPL * 4 * k * (HH - k)) >>> (2 * HL);
    return -((AMPL * 4 * (k - HH) * (2 * HH - k)) >>> (2 * HL));
  endfunction

  function automatic int trap_ref(input int k);
    if (k < RR) return (AMPL * k) >>> RL;
    if (k < RR + HLD) return AMPL;
    if (k < 3 * RR + HLD) return AMPL - ((AMPL * (k - RR - HLD)) >>> RL);
    if (k < 3 * RR + 2 * HLD) return -AMPL;
    return -AMPL + ((AMPL * (k - 3 * RR - 2 * HLD)) >>> RL);
  endfunction

  task automatic drive_g();
    case (g)
      2'd0: {enc_a, enc_b} = 2'b00;
      2'd1: {enc_a, enc_b} = 2'b01;
      2'd2: {enc_a, enc_b} = 2'b11;
      default: {enc_a, enc_b} = 2'b10;
    endcase
  endtask

  task automatic step(input bit up);
    g = up ? g + 2'd1 : g - 2'd1;
    drive_g();
    repeat (FN + 5) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (rst_n && quad_err) err_seen++;

  // R5: velocity monitor on every tick
  always @(negedge clk) if (rst_n) begin
    if (vel_pending) chk("R5 vel", int'(vel), sat12(int'(pos_at_tick) - vel_last_prev));
    vel_pending = 0;
    if (sample_tick) begin
      vel_last_prev = vel_last;
      pos_at_tick = pos;
      vel_last = int'(pos);
      vel_pending = 1;
    end
  end
  int vel_last_prev = 0;
  logic signed [11:0] pos_at_tick = 0;

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    int exp_pos, t0, t1, k;
    repeat (3) @(negedge clk);
    chk("R1 pos in reset", int'(pos), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pos", int'(pos), 0);
    chk("R1 vel", int'(vel), 0);
    chk("R1 ref", int'(ref_pos), 0);
    chk("R1 flags", int'({step_pulse, step_up, quad_err}), 0);

    exp_pos = 0;
    foreach (VEC[i]) begin
      for (int s = 0; s < VEC[i][0]; s++) step(VEC[i][1] != 0);
      exp_pos = VEC[i][2];
      chk("R3 pos after move", int'(pos), exp_pos);
    end

    // R2: glitch shorter than FILT_N
    enc_a = ~enc_a;
    repeat (FN - 1) @(negedge clk);
    enc_a = ~enc_a;
    repeat (FN + 6) @(negedge clk);
    chk("R2 glitch ignored", int'(pos), exp_pos);
    step(1);
    chk("R2 held level accepted", int'(pos), exp_pos + 1);
    exp_pos++;

    // R4: both lines at once
    err_seen = 0;
    enc_a = ~enc_a; enc_b = ~enc_b;
    repeat (FN + 6) @(negedge clk);
    chk("R4 err flagged", err_seen, 1);
    chk("R4 no count", int'(pos), exp_pos);
    enc_a = ~enc_a; enc_b = ~enc_b;
    repeat (FN + 6) @(negedge clk);
    chk("R4 err flagged back", err_seen, 2);
    chk("R4 no count back", int'(pos), exp_pos);

    // R6: tick period
    while (!sample_tick) @(negedge clk);
    t0 = $time;
    @(negedge clk);
    while (!sample_tick) @(negedge clk);
    t1 = $time;
    chk("R6 tick period", (t1 - t0) / CLK_P, DIV);

    // R7: upper saturation
    for (int s = 0; s < 2100; s++) step(1);
    chk("R7 saturate high", int'(pos), 2047);
    step(0);
    chk("R7 leave limit", int'(pos), 2046);

    // R9/R10: trapezoid
    traj_sel = 1;
    @(negedge clk);
    chk("R9 restart to zero", int'(ref_pos), 0);
    k = 0;
    for (int n = 0; n < 30; n++) begin
      while (!sample_tick) @(negedge clk);
      k++;
      @(negedge clk);
      chk("R10 trapezoid", int'(ref_pos), trap_ref(k % (4 * RR + 2 * HLD)));
    end

    // R9/R8: sinusoid
    traj_sel = 0;
    @(negedge clk);
    chk("R9 restart to zero", int'(ref_pos), 0);
    k = 0;
    for (int n = 0; n < 20; n++) begin
      while (!sample_tick) @(negedge clk);
      k++;
      @(negedge clk);
      chk("R8 sinusoid", int'(ref_pos), sine_ref(k % (2 * HH)));
    end
    summary();
  end
endmodule